// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block paces the bus activity of a 16-bit processor core while it enters an interrupt. One accepted request starts a fixed 56-cycle run through thirteen segments: idle slots, misaligned-bus penalty slots, the two halves of the return-address push, the vector-number fetch (interrupt acknowledge), the status-word push, the two handler-address reads and two prefetches. For every cycle of the run it raises one strobe that names the kind of bus work in progress. The surrounding core model uses these strobes to charge time and to order its memory traffic.

The vector number comes from one of two sources. A peripheral supplies its own byte. The video interrupts are autovectored, and their number is a base of 24 plus the request level, so level 2 gives 26, level 4 gives 28 and level 6 gives 30. During the first 24 cycles of a run, the acknowledge window is open. A fresh request at the same level as the one being served may then replace the latched vector, because a second event of the same kind can occur before the fetch completes. Once the window has closed, the vector stays fixed until the run ends. A request at any other level has no effect while the sequencer is busy.

Top module: `intseq_top`

## Requirements
- R1: While synchronous reset is applied, and in the first cycle after it is released, busy, done, the acknowledge window and all phase strobes are low, and the vector number reads 0.
- R2: When the sequencer is idle and a request is sampled at a rising edge, busy is high from the next cycle, which is sequence cycle 1, and stays high for exactly 56 cycles.
- R3: Strobe bits are 0 idle, 1 bus penalty, 2 return-address low write, 3 vector fetch, 4 status write, 5 return-address high write, 6 handler-address high read, 7 handler-address low read, 8 prefetch. Over sequence cycles 1..56 they follow these segments in this order: idle 6, penalty 2, address-low write 4, vector fetch 12, idle 4, status write 4, address-high write 4, handler-high read 4, handler-low read 4, prefetch 4, idle 2, penalty 2, prefetch 4.
- R4: Exactly one strobe bit is high on every busy cycle, and none is high while idle.
- R5: done is high only on sequence cycle 56, and busy is low on the cycle that follows.
- R6: The vector-fetch strobe (bit 3) is high on exactly cycles 13 to 24, so the acknowledge begins 12 cycles into the run and lasts 12 cycles.
- R7: The latched vector is the peripheral byte when the source select is 1. When the select is 0, it is 24 plus the 3-bit level. The vector becomes visible in sequence cycle 1.
- R8: The acknowledge-window output is high on sequence cycles 1 to 24 and low at all other times.
- R9: A request sampled during a window cycle whose level equals the level being served replaces the vector, which is computed as in R7 from the new source select and byte. The new value shows from the next cycle.
- R10: A request at a different level sampled during the window, or any request sampled after the window closes, leaves the vector unchanged through cycle 56.
- R11: A request that arrives while busy, including on the done cycle, neither extends nor restarts the run. The cycle after done is idle.
- R12: Reset asserted in the middle of a run returns the block to the idle state of R1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | Interrupt request, sampled each edge |
| irq_level_i | input | 3 | Priority level of the request |
| vec_src_i | input | 1 | 1 = peripheral byte, 0 = autovector |
| periph_vec_i | input | 8 | Vector byte from the peripheral |
| phase_stb_o | output | 9 | One-hot bus phase strobe |
| ack_win_o | output | 1 | Vector may still be replaced |
| busy_o | output | 1 | Sequence running |
| vec_num_o | output | 8 | Latched vector number |
| done_o | output | 1 | Last cycle of the sequence |

## Verification
Directed runs use the three level/source pairs of the video and peripheral interrupts, so the autovector sum can be told apart from the peripheral byte. Replacement requests are placed at the last window cycle and at the first cycle after it, which checks that the window boundary sits at cycle 24. A same-level request and a different-level request are sent into the window to show that the level comparison, and not the request alone, gates the update. Random runs add requests on arbitrary cycles, including the done cycle. A reset mid-run checks the abort path, and every cycle of every run is compared against the expected segment table.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

    localparam int VEC_W     = 8;
    localparam int LVL_W     = 3;
    localparam int NUM_KINDS = 9;
    localparam int NUM_SEGS  = 13;
    localparam int SEG_W     = $clog2(NUM_SEGS);

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [LVL_W-1:0] lvl_t;

    // Strobe bit position equals the enum value.
    typedef enum logic [3:0] {
        PK_IDLE        = 4'd0,
        PK_PENALTY     = 4'd1,
        PK_PC_LO_WR    = 4'd2,
        PK_VEC_ACK     = 4'd3,
        PK_SR_WR       = 4'd4,
        PK_PC_HI_WR    = 4'd5,
        PK_HADDR_HI_RD = 4'd6,
        PK_HADDR_LO_RD = 4'd7,
        PK_FETCH       = 4'd8
    } phase_kind_e;

    typedef struct packed {
        lvl_t level;
        vec_t num;
    } vec_rec_t;

    function automatic int seg_len_i(seg_t idx);
        case (idx)
            4'd0:    return 6;
            4'd1:    return 2;
            4'd2:    return 4;
            4'd3:    return 12;
            4'd4:    return 4;
            4'd5:    return 4;
            4'd6:    return 4;
            4'd7:    return 4;
            4'd8:    return 4;
            4'd9:    return 4;
            4'd10:   return 2;
            4'd11:   return 2;
            4'd12:   return 4;
            default: return 1;
        endcase
    endfunction

    function automatic phase_kind_e seg_kind(seg_t idx);
        case (idx)
            4'd0:    return PK_IDLE;
            4'd1:    return PK_PENALTY;
            4'd2:    return PK_PC_LO_WR;
            4'd3:    return PK_VEC_ACK;
            4'd4:    return PK_IDLE;
            4'd5:    return PK_SR_WR;
            4'd6:    return PK_PC_HI_WR;
            4'd7:    return PK_HADDR_HI_RD;
            4'd8:    return PK_HADDR_LO_RD;
            4'd9:    return PK_FETCH;
            4'd10:   return PK_IDLE;
            4'd11:   return PK_PENALTY;
            4'd12:   return PK_FETCH;
            default: return PK_IDLE;
        endcase
    endfunction

    function automatic int seq_total();
        int s;
        s = 0;
        for (int i = 0; i < NUM_SEGS; i++) s += seg_len_i(seg_t'(i));
        return s;
    endfunction

    // Cycles up to and including the end of the vector fetch segment.
    function automatic int ack_end();
        int s;
        bit hit;
        s = 0;
        hit = 1'b0;
        for (int i = 0; i < NUM_SEGS; i++) begin
            if (!hit) s += seg_len_i(seg_t'(i));
            if (seg_kind(seg_t'(i)) == PK_VEC_ACK) hit = 1'b1;
        end
        return s;
    endfunction

    localparam int SEQ_LEN = seq_total();
    localparam int WIN_LEN = ack_end();
    localparam int CNT_W   = $clog2(SEQ_LEN);

    typedef logic [CNT_W-1:0] cyc_t;

    function automatic vec_t pick_vector(logic periph, vec_t pvec, lvl_t lvl,
                                         int base);
        return periph ? pvec : vec_t'(base) + vec_t'(lvl);
    endfunction

endpackage

// File: rtl/intseq_timer.sv
module intseq_timer
    import intseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output cyc_t cyc_o,
    output seg_t seg_o,
    output logic last_o
);

    logic busy_q;
    cyc_t cyc_q;
    cyc_t sub_q;
    seg_t seg_q;
    cyc_t sub_end;

    always_comb begin
        sub_end = cyc_t'(seg_len_i(seg_q) - 1);
        last_o  = busy_q && (cyc_q == cyc_t'(SEQ_LEN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
            sub_q  <= '0;
            seg_q  <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                cyc_q  <= '0;
                sub_q  <= '0;
                seg_q  <= '0;
            end
        end else if (last_o) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
            sub_q  <= '0;
            seg_q  <= '0;
        end else begin
            cyc_q <= cyc_q + cyc_t'(1);
            if (sub_q == sub_end) begin
                sub_q <= '0;
                seg_q <= seg_q + seg_t'(1);
            end else begin
                sub_q <= sub_q + cyc_t'(1);
            end
        end
    end

    assign busy_o = busy_q;
    assign cyc_o  = cyc_q;
    assign seg_o  = seg_q;

endmodule

// File: rtl/intseq_decode.sv
module intseq_decode
    import intseq_pkg::*;
(
    input  logic                 busy_i,
    input  seg_t                 seg_i,
    output logic [NUM_KINDS-1:0] stb_o
);

    phase_kind_e kind;

    always_comb kind = seg_kind(seg_i);

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_stb
        assign stb_o[k] = busy_i && (kind == phase_kind_e'(k));
    end

endmodule

// File: rtl/intseq_vector.sv
module intseq_vector
    import intseq_pkg::*;
#(
    parameter int AUTO_BASE = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic win_i,
    input  logic req_i,
    input  lvl_t level_i,
    input  logic periph_i,
    input  vec_t pvec_i,
    output vec_t vec_o
);

    vec_rec_t cur_q;
    logic     take_new;
    logic     take_repl;

    always_comb begin
        take_new  = !busy_i && req_i;
        take_repl = busy_i && win_i && req_i && (level_i == cur_q.level);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (take_new || take_repl) begin
            cur_q.level <= level_i;
            cur_q.num   <= pick_vector(periph_i, pvec_i, level_i, AUTO_BASE);
        end
    end

    assign vec_o = cur_q.num;

endmodule

// File: rtl/intseq_top.sv
module intseq_top
    import intseq_pkg::*;
#(
    parameter int AUTO_BASE = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 irq_req_i,
    input  logic [LVL_W-1:0]     irq_level_i,
    input  logic                 vec_src_i,
    input  logic [VEC_W-1:0]     periph_vec_i,
    output logic [NUM_KINDS-1:0] phase_stb_o,
    output logic                 ack_win_o,
    output logic                 busy_o,
    output logic [VEC_W-1:0]     vec_num_o,
    output logic                 done_o
);

    logic busy;
    cyc_t cyc;
    seg_t seg;
    logic last;
    logic win;

    intseq_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (irq_req_i),
        .busy_o  (busy),
        .cyc_o   (cyc),
        .seg_o   (seg),
        .last_o  (last)
    );

    always_comb win = busy && (cyc < cyc_t'(WIN_LEN));

    intseq_decode u_decode (
        .busy_i (busy),
        .seg_i  (seg),
        .stb_o  (phase_stb_o)
    );

    intseq_vector #(.AUTO_BASE(AUTO_BASE)) u_vector (
        .clk      (clk),
        .rst      (rst),
        .busy_i   (busy),
        .win_i    (win),
        .req_i    (irq_req_i),
        .level_i  (irq_level_i),
        .periph_i (vec_src_i),
        .pvec_i   (periph_vec_i),
        .vec_o    (vec_num_o)
    );

    assign ack_win_o = win;
    assign busy_o    = busy;
    assign done_o    = last;

endmodule

// File: rtl/intseq_chk.sv
module intseq_chk
    import intseq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 irq_req_i,
    input logic [NUM_KINDS-1:0] phase_stb_o,
    input logic                 ack_win_o,
    input logic                 busy_o,
    input logic [VEC_W-1:0]     vec_num_o,
    input logic                 done_o
);

    localparam int ACK_BIT = int'(PK_VEC_ACK);

    // R4
    one_strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> $countones(phase_stb_o) == 1);

    // R4
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> phase_stb_o == '0);

    // R5
    done_ends_run_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    // R5
    done_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    // R6
    fetch_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        phase_stb_o[ACK_BIT] |-> ack_win_o);

    // R8
    window_opens_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ack_win_o);

    // R10
    vector_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !ack_win_o && !done_o) |=> $stable(vec_num_o));

    // R2
    start_run_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && irq_req_i) |=> busy_o);

    // R11
    no_early_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    // R12
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o));

endmodule

bind intseq_top intseq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_req_i   (irq_req_i),
    .phase_stb_o (phase_stb_o),
    .ack_win_o   (ack_win_o),
    .busy_o      (busy_o),
    .vec_num_o   (vec_num_o),
    .done_o      (done_o)
);

// File: tb/tb_intseq_top.sv
`timescale 1ns/1ps
module tb_intseq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [2:0] lvl = '0;
    logic       src = 1'b0;
    logic [7:0] pv  = '0;
    logic [8:0] stb;
    logic       win, busy, done;
    logic [7:0] vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    intseq_top dut (
        .clk(clk), .rst(rst), .irq_req_i(req), .irq_level_i(lvl),
        .vec_src_i(src), .periph_vec_i(pv), .phase_stb_o(stb),
        .ack_win_o(win), .busy_o(busy), .vec_num_o(vec), .done_o(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    // Expected strobe bit for 0-based sequence cycle c (R3 table).
    function automatic int exp_kind(int c);
        if (c < 6)  return 0;
        if (c < 8)  return 1;
        if (c < 12) return 2;
        if (c < 24) return 3;
        if (c < 28) return 0;
        if (c < 32) return 4;
        if (c < 36) return 5;
        if (c < 40) return 6;
        if (c < 44) return 7;
        if (c < 48) return 8;
        if (c < 50) return 0;
        if (c < 52) return 1;
        return 8;
    endfunction

    function automatic logic [7:0] exp_vec(logic s, logic [2:0] l, logic [7:0] p);
        return s ? p : 8'd24 + {5'd0, l};
    endfunction

    task automatic check_idle(input string tag);
        chk({tag, " busy"}, 32'(busy), 0);
        chk({tag, " strobe"}, 32'(stb), 0);
        chk({tag, " done"}, 32'(done), 0);
        chk({tag, " window"}, 32'(win), 0);
    endtask

    // One full run. repl_c >= 0 drives a directed request on that cycle.
    task automatic run_seq(input logic [2:0] l0, input logic s0, input logic [7:0] p0,
                           input int repl_c, input logic [2:0] rl, input logic rs,
                           input logic [7:0] rp, input bit rnd, input bit end_req);
        logic [7:0] ev;
        logic [2:0] el;
        @(negedge clk);
        check_idle("R11 idle before start");
        req = 1'b1; lvl = l0; src = s0; pv = p0;
        ev = exp_vec(s0, l0, p0);
        el = l0;
        for (int c = 0; c < 56; c++) begin
            @(negedge clk);
            chk("R2 busy", 32'(busy), 1);
            chk("R3 R4 R6 strobe", 32'(stb), 32'(9'd1 << exp_kind(c)));
            chk("R5 done", 32'(done), (c == 55) ? 1 : 0);
            chk("R8 window", 32'(win), (c < 24) ? 1 : 0);
            chk("R7 R9 R10 vector", 32'(vec), 32'(ev));
            req = 1'b0;
            if (c == repl_c) begin
                req = 1'b1; lvl = rl; src = rs; pv = rp;
            end else if (rnd && ($urandom % 4 == 0)) begin
                req = 1'b1;
                lvl = ($urandom % 2 == 0) ? el : 3'($urandom % 8);
                src = 1'($urandom % 2);
                pv  = 8'($urandom);
            end else if (c == 55 && end_req) begin
                req = 1'b1; lvl = l0; src = 1'b1; pv = 8'hEE;
            end
            if (req && c < 24 && lvl == el) ev = exp_vec(src, lvl, pv);
        end
        @(negedge clk);
        check_idle("R11 after done");
        chk("R10 vector held", 32'(vec), 32'(ev));
        req = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        chk("R1 vector", 32'(vec), 0);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 after reset");
        chk("R1 vector", 32'(vec), 0);

        // R7: hblank, vblank autovectors and peripheral byte
        run_seq(3'd2, 1'b0, 8'h00, -1, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0);
        run_seq(3'd4, 1'b0, 8'h55, -1, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0);
        run_seq(3'd6, 1'b1, 8'h1E, -1, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0);
        run_seq(3'd6, 1'b1, 8'hA5, -1, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0);
        // R9: same-level replacement at the last window cycle
        run_seq(3'd6, 1'b1, 8'h40, 23, 3'd6, 1'b1, 8'h77, 1'b0, 1'b0);
        // R10: same level just after the window, ignored
        run_seq(3'd6, 1'b1, 8'h41, 24, 3'd6, 1'b1, 8'h99, 1'b0, 1'b0);
        // R10: different level inside the window, ignored
        run_seq(3'd2, 1'b0, 8'h00, 10, 3'd4, 1'b1, 8'h33, 1'b0, 1'b0);
        // R9: early replacement switching to the autovector source
        run_seq(3'd4, 1'b1, 8'h10, 0, 3'd4, 1'b0, 8'h00, 1'b0, 1'b0);
        // R11: request on the done cycle, ignored
        run_seq(3'd6, 1'b1, 8'h20, -1, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1);

        // R12: reset in mid-run
        @(negedge clk);
        req = 1'b1; lvl = 3'd4; src = 1'b0;
        @(negedge clk);
        req = 1'b0;
        repeat (9) @(negedge clk);
        chk("R12 busy before reset", 32'(busy), 1);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R12 after reset");
        chk("R12 vector", 32'(vec), 0);
        rst = 1'b0;

        for (int i = 0; i < 30; i++) begin
            logic [2:0] rl0;
            rl0 = 3'($urandom % 8);
            run_seq(rl0, 1'($urandom % 2), 8'($urandom), -1, 3'd0, 1'b0, 8'h00,
                    1'b1, 1'($urandom % 2));
            repeat ($urandom % 3) begin
                @(negedge clk);
                check_idle("R4 idle gap");
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule